// File: doc/BRIEF.md
# Double-Buffered Frame Memory Controller

This controller sits between a host register/memory port and two frame memory banks, A and B, of an 8-plane colour frame buffer that shows 1152 by 900 pixels. It holds a 16-bit bank control register and an 8-bit plane mask. From them it derives, for each host pixel access, the write enable of each bank, the per-plane write enables and the masked read data. It also derives the bank that the video scan-out shows. The memory arrays, the video timing and the colour map RAMs lie outside. A vertical-retrace level comes in from the timing generator.

Software draws into one bank while the other is shown. To swap banks it writes the new display select together with the wait flag. The controller applies the display select at the next retrace start and clears the wait flag when that retrace ends. It pulses a done output when it clears the flag, so the flip never tears a frame. A colour-map update request uses the same retrace window and is cleared at its end.

Top module: `dbuf_fb_ctrl`

## Requirements
- R1: After reset, ctl_o reads 0x0000, mask_o reads 0xFF, disp_bank_b_o is 0 and swap_done_o is 0.
- R2: A write with ctl_we_i stores wdata_i[15:8] into ctl_o[15:8] and is visible from the next cycle. ctl_o[7:0] always reads zero.
- R3: disp_bank_b_o changes only on the clock where a retrace start is seen: vretrace_i is high, and it was low at the previous clock. It then takes control bit 15. If ctl_we_i is high in that same cycle, it takes wdata_i[15] instead.
- R4: rd_bank_b_o equals control bit 14. pix_rdata_o returns mem_b_rdata_i when that bit is 1 and mem_a_rdata_i when it is 0, in both cases ANDed with the plane mask.
- R5: bank_a_we_o equals pix_we_i AND NOT control bit 12. bank_b_we_o equals pix_we_i AND NOT control bit 13. With both bits clear, one write enables both banks.
- R6: A write with mask_we_i loads wdata_i[7:0] into the plane mask. plane_we_o equals the mask while pix_we_i is high and is zero otherwise.
- R7: The wait flag (bit 9) stays set until a retrace end: vretrace_i is low, and it was high at the previous clock. On that clock it is cleared. A host write in the same cycle takes precedence over the clear.
- R8: swap_done_o is high for exactly the one cycle after a retrace end at which the wait flag was set.
- R9: The colour-map update bit (bit 8) is cleared at every retrace end, with the same write precedence as R7. cmap_xfer_o equals bit 8 AND vretrace_i.
- R10: cmap_to_map_o follows control bit 11 and fast_rd_o follows control bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vretrace_i | input | 1 | Vertical retrace level |
| ctl_we_i | input | 1 | Write control register |
| mask_we_i | input | 1 | Write plane mask |
| wdata_i | input | 16 | Register write data |
| ctl_o | output | 16 | Control register contents |
| mask_o | output | 8 | Plane mask contents |
| pix_we_i | input | 1 | Host pixel write strobe |
| mem_a_rdata_i | input | 8 | Pixel read data from bank A |
| mem_b_rdata_i | input | 8 | Pixel read data from bank B |
| pix_rdata_o | output | 8 | Masked pixel read data to host |
| bank_a_we_o | output | 1 | Bank A write enable |
| bank_b_we_o | output | 1 | Bank B write enable |
| plane_we_o | output | 8 | Per-plane write enables |
| rd_bank_b_o | output | 1 | Host read bank select (1 = B) |
| disp_bank_b_o | output | 1 | Scan-out bank select (1 = B) |
| fast_rd_o | output | 1 | Fast-read mode bit |
| cmap_xfer_o | output | 1 | Colour-map copy request during retrace |
| cmap_to_map_o | output | 1 | Copy direction (1 = into the map) |
| swap_done_o | output | 1 | Pulse when the wait flag is cleared |

## Verification
Two collisions need directed cases. A host control write can land on the exact clock of a retrace end, where it competes with the hardware clear of the wait and update bits. A host write of the display select can land on the exact clock of a retrace start. The stimulus keeps a fixed retrace period and forces register writes on those two phases in chosen frames, while random traffic covers the rest. A behavioural model applies write precedence, the done pulse and the forwarded display select. It is compared with every output on every cycle.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int CTL_W = 16;
  localparam int RSVD_W = 8;

  // field order is the register bit order, msb first
  typedef struct packed {
    logic              disp_b;
    logic              rd_b;
    logic              nowr_b;
    logic              nowr_a;
    logic              cmap_to_map;
    logic              fast_rd;
    logic              wait_f;
    logic              cmap_upd;
    logic [RSVD_W-1:0] rsvd;
  } dbuf_ctl_t;
endpackage

// File: rtl/dbuf_retrace_edge.sv
module dbuf_retrace_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vretrace_i,
  output logic start_o,
  output logic end_o
);
  logic ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ret_q <= 1'b0;
    else         ret_q <= vretrace_i;
  end

  assign start_o = vretrace_i & ~ret_q;
  assign end_o   = ret_q & ~vretrace_i;

  // R7
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && end_o));
endmodule

// File: rtl/dbuf_ctl_reg.sv
module dbuf_ctl_reg
  import dbuf_pkg::*;
#(
  parameter int NUM_PLANES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ctl_we_i,
  input  logic                  mask_we_i,
  input  logic [CTL_W-1:0]      wdata_i,
  input  logic                  ret_start_i,
  input  logic                  ret_end_i,
  output dbuf_ctl_t             ctl_o,
  output logic [NUM_PLANES-1:0] mask_o,
  output logic                  disp_b_o,
  output logic                  done_o
);
  dbuf_ctl_t             ctl_q, ctl_d, wr_val;
  logic [NUM_PLANES-1:0] mask_q;
  logic                  disp_q, done_q;

  always_comb begin
    wr_val      = dbuf_ctl_t'(wdata_i);
    wr_val.rsvd = '0;
    ctl_d       = ctl_q;
    if (ret_end_i) begin
      ctl_d.wait_f   = 1'b0;
      ctl_d.cmap_upd = 1'b0;
    end
    // host write wins over the retrace-end clear
    if (ctl_we_i) ctl_d = wr_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      mask_q <= '1;
      disp_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      done_q <= ret_end_i & ctl_q.wait_f;
      if (mask_we_i)   mask_q <= wdata_i[NUM_PLANES-1:0];
      // same-cycle write of the display bit is forwarded
      if (ret_start_i) disp_q <= ctl_we_i ? wr_val.disp_b : ctl_q.disp_b;
    end
  end

  assign ctl_o    = ctl_q;
  assign mask_o   = mask_q;
  assign disp_b_o = disp_q;
  assign done_o   = done_q;

  // R7
  wait_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_end_i && !ctl_we_i) |=> !ctl_q.wait_f);
  // R9
  upd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_end_i && !ctl_we_i) |=> !ctl_q.cmap_upd);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  disp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_start_i |=> $stable(disp_q));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (ctl_q.rsvd == '0));
endmodule

// File: rtl/dbuf_bank_route.sv
module dbuf_bank_route #(
  parameter int NUM_PLANES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pix_we_i,
  input  logic                  rd_b_i,
  input  logic                  nowr_a_i,
  input  logic                  nowr_b_i,
  input  logic [NUM_PLANES-1:0] mask_i,
  input  logic [NUM_PLANES-1:0] mem_a_rdata_i,
  input  logic [NUM_PLANES-1:0] mem_b_rdata_i,
  output logic [NUM_PLANES-1:0] pix_rdata_o,
  output logic                  bank_a_we_o,
  output logic                  bank_b_we_o,
  output logic [NUM_PLANES-1:0] plane_we_o
);
  assign bank_a_we_o = pix_we_i & ~nowr_a_i;
  assign bank_b_we_o = pix_we_i & ~nowr_b_i;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    assign plane_we_o[p]  = pix_we_i & mask_i[p];
    assign pix_rdata_o[p] = mask_i[p] & (rd_b_i ? mem_b_rdata_i[p] : mem_a_rdata_i[p]);
  end

  // R6
  plane_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plane_we_o & ~mask_i) == '0);
  // R5
  bank_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_a_we_o || bank_b_we_o) |-> pix_we_i);
endmodule

// File: rtl/dbuf_fb_ctrl.sv
module dbuf_fb_ctrl
  import dbuf_pkg::*;
#(
  parameter int NUM_PLANES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vretrace_i,
  input  logic                  ctl_we_i,
  input  logic                  mask_we_i,
  input  logic [CTL_W-1:0]      wdata_i,
  output logic [CTL_W-1:0]      ctl_o,
  output logic [NUM_PLANES-1:0] mask_o,
  input  logic                  pix_we_i,
  input  logic [NUM_PLANES-1:0] mem_a_rdata_i,
  input  logic [NUM_PLANES-1:0] mem_b_rdata_i,
  output logic [NUM_PLANES-1:0] pix_rdata_o,
  output logic                  bank_a_we_o,
  output logic                  bank_b_we_o,
  output logic [NUM_PLANES-1:0] plane_we_o,
  output logic                  rd_bank_b_o,
  output logic                  disp_bank_b_o,
  output logic                  fast_rd_o,
  output logic                  cmap_xfer_o,
  output logic                  cmap_to_map_o,
  output logic                  swap_done_o
);
  logic                  ret_start, ret_end;
  dbuf_ctl_t             ctl;
  logic [NUM_PLANES-1:0] mask;

  dbuf_retrace_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vretrace_i (vretrace_i),
    .start_o    (ret_start),
    .end_o      (ret_end)
  );

  dbuf_ctl_reg #(.NUM_PLANES(NUM_PLANES)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .mask_we_i   (mask_we_i),
    .wdata_i     (wdata_i),
    .ret_start_i (ret_start),
    .ret_end_i   (ret_end),
    .ctl_o       (ctl),
    .mask_o      (mask),
    .disp_b_o    (disp_bank_b_o),
    .done_o      (swap_done_o)
  );

  dbuf_bank_route #(.NUM_PLANES(NUM_PLANES)) u_route (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pix_we_i      (pix_we_i),
    .rd_b_i        (ctl.rd_b),
    .nowr_a_i      (ctl.nowr_a),
    .nowr_b_i      (ctl.nowr_b),
    .mask_i        (mask),
    .mem_a_rdata_i (mem_a_rdata_i),
    .mem_b_rdata_i (mem_b_rdata_i),
    .pix_rdata_o   (pix_rdata_o),
    .bank_a_we_o   (bank_a_we_o),
    .bank_b_we_o   (bank_b_we_o),
    .plane_we_o    (plane_we_o)
  );

  assign ctl_o         = ctl;
  assign mask_o        = mask;
  assign rd_bank_b_o   = ctl.rd_b;
  assign fast_rd_o     = ctl.fast_rd;
  assign cmap_to_map_o = ctl.cmap_to_map;
  assign cmap_xfer_o   = ctl.cmap_upd & vretrace_i;

  // R9
  xfer_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmap_xfer_o |-> vretrace_i);
endmodule

// File: tb/dbuf_fb_ctrl_test.sv
module dbuf_fb_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vret = 1'b0, ctl_we = 1'b0, mask_we = 1'b0, pix_we = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  mem_a = '0, mem_b = '0;
  logic [15:0] ctl_o;
  logic [7:0]  mask_o, rdata_o, plane_we_o;
  logic        a_we_o, b_we_o, rd_b_o, disp_o, fast_o, xfer_o, to_map_o, done_o;

  int checks = 0, errors = 0;
  bit run_chk = 0;

  always #5 clk = ~clk;

  dbuf_fb_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .vretrace_i(vret), .ctl_we_i(ctl_we),
    .mask_we_i(mask_we), .wdata_i(wdata), .ctl_o(ctl_o), .mask_o(mask_o),
    .pix_we_i(pix_we), .mem_a_rdata_i(mem_a), .mem_b_rdata_i(mem_b),
    .pix_rdata_o(rdata_o), .bank_a_we_o(a_we_o), .bank_b_we_o(b_we_o),
    .plane_we_o(plane_we_o), .rd_bank_b_o(rd_b_o), .disp_bank_b_o(disp_o),
    .fast_rd_o(fast_o), .cmap_xfer_o(xfer_o), .cmap_to_map_o(to_map_o),
    .swap_done_o(done_o)
  );

  // behavioural reference state
  logic [15:0] m_ctl = '0;
  logic [7:0]  m_mask = 8'hFF;
  logic        m_disp = 0, m_done = 0, m_ret = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_mask = 8'hFF; m_disp = 0; m_done = 0; m_ret = 0;
    end else begin
      logic        ev_end, ev_start;
      logic [15:0] nxt;
      ev_end   = m_ret && !vret;
      ev_start = !m_ret && vret;
      m_done   = ev_end && m_ctl[9];
      nxt = m_ctl;
      if (ev_end) nxt = nxt & ~16'h0300;
      if (ctl_we) nxt = wdata & 16'hFF00;
      if (ev_start) m_disp = ctl_we ? wdata[15] : m_ctl[15];
      if (mask_we) m_mask = wdata[7:0];
      m_ctl = nxt;
      m_ret = vret;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run_chk) begin
    chk("R2 ctl",          ctl_o, m_ctl);
    chk("R6 mask",         mask_o, m_mask);
    chk("R3 disp",         disp_o, m_disp);
    chk("R4 rd_bank",      rd_b_o, m_ctl[14]);
    chk("R4 rdata",        rdata_o, (m_ctl[14] ? mem_b : mem_a) & m_mask);
    chk("R5 a_we",         a_we_o, pix_we && !m_ctl[12]);
    chk("R5 b_we",         b_we_o, pix_we && !m_ctl[13]);
    chk("R6 plane_we",     plane_we_o, pix_we ? m_mask : 8'h00);
    chk("R7 wait",         ctl_o[9], m_ctl[9]);
    chk("R8 done",         done_o, m_done);
    chk("R9 xfer",         xfer_o, m_ctl[8] && vret);
    chk("R10 to_map",      to_map_o, m_ctl[11]);
    chk("R10 fast",        fast_o, m_ctl[10]);
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl_o, 16'h0000);
    chk("R1 mask", mask_o, 8'hFF);
    chk("R1 disp", disp_o, 1'b0);
    chk("R1 done", done_o, 1'b0);
    #1 rst_n = 1'b1;
    run_chk = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int ph, fr;
      @(negedge clk); #1;
      ph = cyc % 20; fr = cyc / 20;
      vret   = (ph >= 10 && ph <= 14);
      ctl_we = ($urandom_range(0, 15) == 0);
      mask_we = ($urandom_range(0, 31) == 0);
      wdata  = 16'($urandom);
      pix_we = $urandom_range(0, 1);
      mem_a  = 8'($urandom);
      mem_b  = 8'($urandom);
      // directed collisions
      if (fr % 4 == 0 && ph == 3) begin ctl_we = 1; wdata[9] = 1; wdata[8] = 1; end
      if (fr % 4 == 0 && ph > 3) ctl_we = 0;
      if (fr % 4 == 1 && ph == 15) begin ctl_we = 1; wdata[9] = fr[3]; end // R7 write vs end
      if (fr % 4 == 2 && ph == 10) ctl_we = 1;                         // R3 write vs start
      if (fr % 8 == 3 && ph < 16) ctl_we = 0;                          // R8 undisturbed swap
    end
    @(negedge clk);
    run_chk = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule